// File: doc/BRIEF.md
# UART Modem Control and Status Unit

This block sits beside a UART's transmit and receive shifters and handles the modem handshake lines. A control byte drives the active-low DTR and RTS pins and two general-purpose outputs. It also selects loopback and produces the enables for automatic RTS and CTS flow control, which logic elsewhere uses. The four modem inputs CTS, DSR, RI and DCD are synchronized and form the upper nibble of a status byte. The lower nibble holds change flags that stay set until the status byte is read. An interrupt output is high while any change flag is set and the interrupt is enabled.

Loopback is for diagnostics. The transmitter's serial output goes straight back to the receiver's serial input. The external serial and modem outputs sit at their idle level, and the external inputs are ignored. The modem control bits drive the status lines instead, so software can raise modem-status interrupts just by writing the control byte. While loopback is on, the DTR and RTS control bits read back as zero.

Top module: `uart_modem_ctrl`

## Requirements
- R1: After reset the control byte is 0x00. DTR, RTS and both general-purpose pins are high, every change flag is clear and the interrupt is low.
- R2: A write to the control address stores bit 0 (DTR), bit 1 (RTS), bit 2 (general output 1), bit 3 (general output 2), bit 4 (loopback), bit 6 (automatic RTS enable) and bit 7 (automatic CTS enable). Bit 5 always reads 0. Outside loopback each modem pin is the inverse of its bit, and the two flow-control enable outputs follow bits 6 and 7.
- R3: At the status address, bit 4 is CTS, bit 5 is DSR, bit 6 is RI and bit 7 is DCD. Each bit is the inverse of its pin, seen after SYNC_STAGES clock edges: with the default, the status changes after the second edge and not after the first.
- R4: Status bit 0 sets on any change of CTS, bit 1 on any change of DSR and bit 3 on any change of DCD. Bit 2 sets only when RI goes from active to inactive. Each flag sets one edge after the status level changes.
- R5: A read of the status address returns the current flags and then clears them.
- R6: The interrupt output is high exactly while the interrupt enable input is high and at least one change flag is set.
- R7: In loopback, the receiver serial output equals the transmitter serial input, the external RXD pin has no effect, and TXD is held high.
- R8: In loopback, DTR, RTS and both general-purpose pins are held high, and changes on the external modem inputs do not reach the status byte.
- R9: In loopback, CTS status follows control bit 1, DSR bit 0, RI bit 2 and DCD bit 3. Changes caused by control writes set the flags exactly as in R4.
- R10: While loopback is on, control bits 0 and 1 read as 0. Their stored values return on readback and at the pins once loopback is off.
- R11: Outside loopback, TXD equals the transmitter serial input and the receiver serial output equals RXD.
- R12: Addresses other than the control and status addresses read as 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Register address (control 0, status 1) |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe; at the status address it clears the flags |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register |
| msi_en_i | input | 1 | Modem-status interrupt enable |
| msi_irq_o | output | 1 | Modem-status interrupt |
| ser_tx_i | input | 1 | Serial output from the transmit shifter |
| ser_rx_o | output | 1 | Serial input to the receive shifter |
| txd_o | output | 1 | External transmit pin |
| rxd_i | input | 1 | External receive pin |
| cts_ni | input | 1 | Clear-to-send pin, active low |
| dsr_ni | input | 1 | Data-set-ready pin, active low |
| ri_ni | input | 1 | Ring-indicator pin, active low |
| dcd_ni | input | 1 | Carrier-detect pin, active low |
| dtr_no | output | 1 | Data-terminal-ready pin, active low |
| rts_no | output | 1 | Request-to-send pin, active low |
| gpo1_no | output | 1 | General-purpose output 1, active low |
| gpo2_no | output | 1 | General-purpose output 2, active low |
| auto_rts_en_o | output | 1 | Enable for automatic RTS flow control |
| auto_cts_en_o | output | 1 | Enable for automatic CTS flow control |

## Verification
The bench uses the defaults: ADDR_W of 2, control at address 0, status at 1 and a two-stage synchronizer. The two-stage synchronizer makes the edge-by-edge latency directly visible, with no status change one edge after a pin moves and a change after two. The 2-bit address leaves addresses 2 and 3 free, so writes to unmapped space and reads from it can be checked. Loopback is entered and left with the modem lines in both states, so the flags raised by a mode switch are checked as well as those from the inputs.

// File: rtl/uart_mdm_pkg.sv
package uart_mdm_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned LINE_N = 4;

  // status nibble line positions (status bits 4..7 / flag bits 0..3)
  localparam int unsigned LN_CTS = 0;
  localparam int unsigned LN_DSR = 1;
  localparam int unsigned LN_RI  = 2;
  localparam int unsigned LN_DCD = 3;

  typedef struct packed {
    logic cts_auto;
    logic rts_auto;
    logic rsvd;
    logic loop;
    logic gpo2;
    logic gpo1;
    logic rts;
    logic dtr;
  } mdm_ctrl_t;

  localparam logic [REG_W-1:0] CTRL_WMASK = 8'hDF;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int unsigned          W       = 4,
  parameter int unsigned          STAGES  = 2,
  parameter logic        [W-1:0]  RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import uart_mdm_pkg::*;
#(
  parameter int unsigned              ADDR_W    = 2,
  parameter logic        [ADDR_W-1:0] CTRL_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output mdm_ctrl_t         ctrl_o
);
  mdm_ctrl_t ctrl_q;
  logic      sel;

  assign sel = wr_i && (addr_i == CTRL_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)  ctrl_q <= '0;
    else if (sel) ctrl_q <= mdm_ctrl_t'(wdata_i & CTRL_WMASK);

  assign ctrl_o = ctrl_q;

  // R12
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == CTRL_ADDR) |=> $stable(ctrl_o));
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta
  import uart_mdm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_N-1:0] lvl_i,
  input  logic              clr_i,
  output logic [LINE_N-1:0] flag_o
);
  logic [LINE_N-1:0] prev_q;
  logic [LINE_N-1:0] flag_q;
  logic [LINE_N-1:0] hit;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;

  for (genvar i = 0; i < LINE_N; i++) begin : g_ln
    if (i == LN_RI) begin : g_trail
      assign hit[i] = prev_q[i] & ~lvl_i[i];
      // R4
      ri_no_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!prev_q[i] && !flag_q[i]) |=> !flag_q[i]);
    end else begin : g_any
      assign hit[i] = prev_q[i] ^ lvl_i[i];
      // R4
      chg_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lvl_i[i] != prev_q[i]) |=> flag_q[i]);
    end

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) flag_q[i] <= 1'b0;
      else         flag_q[i] <= hit[i] | (flag_q[i] & ~clr_i);
  end

  assign flag_o = flag_q;

  // R5
  rd_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && lvl_i == prev_q) |=> (flag_o == '0));
endmodule

// File: rtl/uart_modem_ctrl.sv
module uart_modem_ctrl
  import uart_mdm_pkg::*;
#(
  parameter int unsigned              ADDR_W      = 2,
  parameter logic        [ADDR_W-1:0] CTRL_ADDR   = 0,
  parameter logic        [ADDR_W-1:0] STAT_ADDR   = 1,
  parameter int unsigned              SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              msi_en_i,
  output logic              msi_irq_o,
  input  logic              ser_tx_i,
  output logic              ser_rx_o,
  output logic              txd_o,
  input  logic              rxd_i,
  input  logic              cts_ni,
  input  logic              dsr_ni,
  input  logic              ri_ni,
  input  logic              dcd_ni,
  output logic              dtr_no,
  output logic              rts_no,
  output logic              gpo1_no,
  output logic              gpo2_no,
  output logic              auto_rts_en_o,
  output logic              auto_cts_en_o
);
  mdm_ctrl_t         ctrl;
  logic [LINE_N-1:0] pin_raw, pin_sync, ext_lvl, loop_lvl, lvl, flags;
  logic              stat_clr;

  mdm_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(reg_addr_i),
    .wr_i(reg_wr_i), .wdata_i(reg_wdata_i), .ctrl_o(ctrl)
  );

  assign pin_raw = {dcd_ni, ri_ni, dsr_ni, cts_ni};

  mdm_sync #(.W(LINE_N), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_raw), .q_o(pin_sync)
  );

  assign ext_lvl  = ~pin_sync;
  // loopback wiring: rts->cts, dtr->dsr, gpo1->ri, gpo2->dcd
  assign loop_lvl = {ctrl.gpo2, ctrl.gpo1, ctrl.dtr, ctrl.rts};
  assign lvl      = ctrl.loop ? loop_lvl : ext_lvl;
  assign stat_clr = reg_rd_i && (reg_addr_i == STAT_ADDR);

  mdm_delta u_delta (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .clr_i(stat_clr), .flag_o(flags)
  );

  assign msi_irq_o = msi_en_i && (|flags);

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == CTRL_ADDR)
      reg_rdata_o = {ctrl[7:2], ctrl.loop ? 2'b00 : ctrl[1:0]};
    else if (reg_addr_i == STAT_ADDR)
      reg_rdata_o = {lvl, flags};
  end

  assign txd_o    = ctrl.loop ? 1'b1 : ser_tx_i;
  assign ser_rx_o = ctrl.loop ? ser_tx_i : rxd_i;
  assign dtr_no   = ctrl.loop | ~ctrl.dtr;
  assign rts_no   = ctrl.loop | ~ctrl.rts;
  assign gpo1_no  = ctrl.loop | ~ctrl.gpo1;
  assign gpo2_no  = ctrl.loop | ~ctrl.gpo2;

  assign auto_rts_en_o = ctrl.rts_auto;
  assign auto_cts_en_o = ctrl.cts_auto;

  // R8
  loop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.loop |-> (dtr_no && rts_no && gpo1_no && gpo2_no && txd_o));
  // R10
  loop_rdmask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.loop && reg_addr_i == CTRL_ADDR) |-> (reg_rdata_o[1:0] == 2'b00));
  // R6
  irq_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_irq_o |-> (reg_addr_i != STAT_ADDR || reg_rdata_o[3:0] != '0));
  // R7
  loop_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.loop |-> (ser_rx_o == ser_tx_i));
endmodule

// File: tb/tb_uart_modem_ctrl.sv
module tb_uart_modem_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 0, rd = 0, msi_en = 1;
  logic [7:0] wdata = '0, rdata;
  logic       irq, ser_tx = 1, ser_rx, txd, rxd = 1;
  logic       cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  logic       dtr_n, rts_n, g1_n, g2_n, arts, acts;
  int         n_chk = 0, n_fail = 0;
  logic [7:0] v;

  always #2 clk = ~clk;

  uart_modem_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .msi_en_i(msi_en), .msi_irq_o(irq),
    .ser_tx_i(ser_tx), .ser_rx_o(ser_rx), .txd_o(txd), .rxd_i(rxd),
    .cts_ni(cts_n), .dsr_ni(dsr_n), .ri_ni(ri_n), .dcd_ni(dcd_n),
    .dtr_no(dtr_n), .rts_no(rts_n), .gpo1_no(g1_n), .gpo2_no(g2_n),
    .auto_rts_en_o(arts), .auto_cts_en_o(acts)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  function automatic logic [7:0] pins();
    return {4'b0, g2_n, g1_n, rts_n, dtr_n};
  endfunction

  task automatic t_reset;
    peek(0, v); chk("R1 ctrl", v, 8'h00);
    peek(1, v); chk("R1 status", v, 8'h00);
    chk("R1 pins", pins(), 8'h0F);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_ctrl;
    wr_reg(0, 8'hEF);
    rd_reg(0, v); chk("R2 read bit5 zero", v, 8'hCF);
    chk("R2 pins low", pins(), 8'h00);
    chk("R2 auto enables", {6'b0, acts, arts}, 8'h03);
    wr_reg(0, 8'h02);
    rd_reg(0, v); chk("R2 read", v, 8'h02);
    chk("R2 pins", pins(), 8'h0D);
    chk("R2 auto off", {6'b0, acts, arts}, 8'h00);
    wr_reg(0, 8'h00);
  endtask

  task automatic t_status;
    addr = 1;
    @(negedge clk); cts_n = 0;
    @(negedge clk); #1 chk("R3 one edge", rdata, 8'h00);
    @(negedge clk); #1 chk("R3 two edges", rdata, 8'h10);
    @(negedge clk); #1 chk("R4 cts flag", rdata, 8'h11);
    rd_reg(1, v); chk("R5 read value", v, 8'h11);
    peek(1, v); chk("R5 cleared", v, 8'h10);
    @(negedge clk); dsr_n = 0; dcd_n = 0;
    idle(4); peek(1, v); chk("R4 dsr dcd", v, 8'hBA);
    rd_reg(1, v);
    @(negedge clk); cts_n = 1; dsr_n = 1; dcd_n = 1;
    idle(4); peek(1, v); chk("R4 release", v, 8'h0B);
    rd_reg(1, v);
  endtask

  task automatic t_ri;
    @(negedge clk); ri_n = 0;
    idle(4); peek(1, v); chk("R4 ri leading no flag", v, 8'h40);
    @(negedge clk); ri_n = 1;
    idle(4); peek(1, v); chk("R4 ri trailing flag", v, 8'h04);
    rd_reg(1, v); peek(1, v); chk("R5 ri cleared", v, 8'h00);
  endtask

  task automatic t_irq;
    msi_en = 0;
    @(negedge clk); cts_n = 0;
    idle(4); #1 chk("R6 disabled", {7'b0, irq}, 8'h00);
    msi_en = 1; #1 chk("R6 enabled", {7'b0, irq}, 8'h01);
    rd_reg(1, v); #1 chk("R6 after clear", {7'b0, irq}, 8'h00);
    @(negedge clk); cts_n = 1;
    idle(4); rd_reg(1, v);
  endtask

  task automatic t_serial;
    wr_reg(0, 8'h10);
    ser_tx = 0; rxd = 1; #1;
    chk("R7 rx from tx 0", {6'b0, txd, ser_rx}, 8'h02);
    ser_tx = 1; rxd = 0; #1;
    chk("R7 rx from tx 1", {6'b0, txd, ser_rx}, 8'h03);
    wr_reg(0, 8'h00);
    idle(2); rd_reg(1, v);
    ser_tx = 0; rxd = 1; #1;
    chk("R11 normal", {6'b0, txd, ser_rx}, 8'h01);
    ser_tx = 1; rxd = 0; #1;
    chk("R11 normal swap", {6'b0, txd, ser_rx}, 8'h02);
    rxd = 1;
  endtask

  task automatic t_loop;
    rd_reg(1, v);
    wr_reg(0, 8'h1F);
    chk("R8 pins idle", pins(), 8'h0F);
    rd_reg(0, v); chk("R10 read masked", v, 8'h1C);
    peek(1, v); chk("R9 loop status", v, 8'hFB);
    rd_reg(1, v);
    @(negedge clk); cts_n = 0; dsr_n = 0; ri_n = 0; dcd_n = 0;
    idle(4); peek(1, v); chk("R8 inputs ignored", v, 8'hF0);
    @(negedge clk); cts_n = 1; dsr_n = 1; ri_n = 1; dcd_n = 1;
    idle(4);
    wr_reg(0, 8'h1B);
    idle(1); peek(1, v); chk("R9 ri from write", v, 8'hB4);
    #1 chk("R9 irq from write", {7'b0, irq}, 8'h01);
    rd_reg(1, v);
    wr_reg(0, 8'h03);
    rd_reg(0, v); chk("R10 restored", v, 8'h03);
    chk("R10 pins restored", pins(), 8'h0C);
    idle(2); rd_reg(1, v);
  endtask

  task automatic t_unmapped;
    wr_reg(2, 8'hFF);
    wr_reg(3, 8'h10);
    rd_reg(0, v); chk("R12 ctrl kept", v, 8'h03);
    rd_reg(3, v); chk("R12 read zero", v, 8'h00);
    wr_reg(0, 8'h00);
  endtask

  initial begin
    fork
      begin
        idle(3); rst_n = 1; idle(1);
        t_reset; t_ctrl; t_status; t_ri; t_irq; t_serial; t_loop; t_unmapped;
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule